// File: doc/BRIEF.md
# I2C Arbitration Loss Monitor

This block sits beside the bit engine of an I2C master transmitter and watches for lost arbitration. The SCL and SDA bus levels pass through synchronizers into the system clock domain. On every rising SCL edge the block compares the bit the engine is driving with the level sampled on the bus. A mismatch means another master is pulling SDA low, so this master has lost the bus.

A mode input selects how the loss flag reports the result. In live mode the flag follows each compare. In frame mode any mismatch in a 9-clock frame (8 data bits and an acknowledge) is collected in a sticky register. It is committed to the flag on the falling SCL edge that closes the 9th bit, and after that only a clear request takes it down. A release enable lets the block drop the SDA output enable in the same cycle the flag sets. A one-cycle event pulse marks each 0-to-1 change of the flag.

Top module: `i2c_arb_monitor`

## Requirements
- R1: While and after reset, with no bus activity, lossFlag and lossEvent are 0 and sdaOe equals driveEn.
- R2: A rising SCL edge is compared against the synchronized SDA level. The flag update it causes appears on the outputs after the 3rd system clock edge following the SCL pin change, and not after the 2nd.
- R3: With byteMode=0 (live mode), each compared rising edge sets lossFlag to 1 on a mismatch and to 0 on a match.
- R4: With byteMode=1 (frame mode), a mismatch on any compared edge of a frame does not change lossFlag until the falling SCL edge of the 9th bit, where lossFlag becomes 1.
- R5: With byteMode=1, lossFlag stays 1 through later matching bits and frames until flagClr is asserted.
- R6: No compare takes place while driveEn is 0. No compare takes place on the 9th bit of a frame while ackRecv is 1. On the 9th bit with ackRecv=0 the bit is compared as usual.
- R7: When releaseEn is 1, sdaOe goes to 0 in the same cycle lossFlag becomes 1. It stays 0, even after the flag clears through a match, until flagClr or reset.
- R8: lossEvent is 1 for exactly one system clock, in the cycle lossFlag changes from 0 to 1, and is 0 otherwise.
- R9: If flagClr is asserted in the same cycle that a set takes effect, the set wins and lossFlag becomes 1.
- R10: frameStart returns the bit counter to the first bit and discards the collected frame-mode mismatch. The next frame end is the 9th SCL fall after frameStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL bus level |
| sdaIn | input | 1 | SDA bus level |
| txBit | input | 1 | Bit being driven by the local transmitter |
| driveEn | input | 1 | Local transmitter is driving SDA |
| ackRecv | input | 1 | 9th bit is an acknowledge received from the far side |
| byteMode | input | 1 | 0: live per-bit flag, 1: frame-committed sticky flag |
| releaseEn | input | 1 | Drop SDA output enable when the flag sets |
| flagClr | input | 1 | Software clear of the flag and of the SDA release |
| frameStart | input | 1 | Restart the bit counter at the first bit of a frame |
| lossFlag | output | 1 | Arbitration loss flag |
| sdaOe | output | 1 | SDA output driver enable |
| lossEvent | output | 1 | One-cycle pulse when the flag rises |

## Verification
The assertions assume that txBit, driveEn, ackRecv, releaseEn and byteMode stay steady around each synchronized SCL edge. They also assume that byteMode does not change while a frame-mode flag is held. The directed stimulus changes these inputs only while SCL has been low for several system clocks, and it switches mode only after a clear. Each SCL phase is held for four system clocks, which is longer than the synchronizer depth plus edge detection. Because of that, every rising and falling edge is seen exactly once.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  // strobes handed from control to datapath, one system clock wide
  typedef struct packed {
    logic sclRise;   // synchronized SCL rising edge
    logic frameEnd;  // SCL fall that closes the last bit of the frame
    logic cmpValid;  // compare allowed for the current bit
    logic frameRst;  // frame restart request
    logic sdaLvl;    // synchronized SDA level
  } arbStrobes_t;
endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= RESET_VAL;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_arb_ctrl.sv
module i2c_arb_ctrl
  import i2c_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        driveEn,
  input  logic        ackRecv,
  input  logic        frameStart,
  output arbStrobes_t strb
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic sclSync, sdaSync, sclPrev;
  logic sclRise, sclFall;
  logic [CNT_W-1:0] bitCnt;
  logic onLastBit;

  i2c_arb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync)
  );
  i2c_arb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclPrev <= 1'b1;
    else       sclPrev <= sclSync;
  end

  assign sclRise   = sclSync & ~sclPrev;
  assign sclFall   = ~sclSync & sclPrev;
  assign onLastBit = (bitCnt == LAST_IDX);

  // bit position inside the frame, advanced on each SCL fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bitCnt <= '0;
    else if (frameStart) bitCnt <= '0;
    else if (sclFall)    bitCnt <= onLastBit ? '0 : bitCnt + 1'b1;
  end

  always_comb begin
    strb.sclRise  = sclRise;
    strb.frameEnd = sclFall & onLastBit & ~frameStart;
    strb.cmpValid = driveEn & ~(ackRecv & onLastBit);
    strb.frameRst = frameStart;
    strb.sdaLvl   = sdaSync;
  end
endmodule

// File: rtl/i2c_arb_dp.sv
module i2c_arb_dp
  import i2c_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  arbStrobes_t strb,
  input  logic        txBit,
  input  logic        driveEn,
  input  logic        byteMode,
  input  logic        releaseEn,
  input  logic        flagClr,
  output logic        lossFlag,
  output logic        sdaOe,
  output logic        lossEvent
);
  logic cmpHit, mismatch;
  logic setNow, liveClear;
  logic flagQ, stickyQ, releasedQ, eventQ;

  assign mismatch = strb.sdaLvl ^ txBit;
  assign cmpHit   = strb.sclRise & strb.cmpValid;

  always_comb begin
    setNow    = 1'b0;
    liveClear = 1'b0;
    if (!byteMode) begin
      if (cmpHit) begin
        setNow    = mismatch;
        liveClear = ~mismatch;
      end
    end else begin
      setNow = strb.frameEnd & stickyQ;
    end
  end

  // frame-mode mismatch collector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                stickyQ <= 1'b0;
    else if (strb.frameRst || strb.frameEnd)  stickyQ <= 1'b0;
    else if (byteMode && cmpHit && mismatch)  stickyQ <= 1'b1;
  end

  // flag: a set outranks any clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       flagQ <= 1'b0;
    else if (setNow)                 flagQ <= 1'b1;
    else if (flagClr || liveClear)   flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     releasedQ <= 1'b0;
    else if (setNow && releaseEn)  releasedQ <= 1'b1;
    else if (flagClr)              releasedQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eventQ <= 1'b0;
    else       eventQ <= setNow & ~flagQ;
  end

  assign lossFlag  = flagQ;
  assign lossEvent = eventQ;
  assign sdaOe     = driveEn & ~releasedQ;
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic txBit,
  input  logic driveEn,
  input  logic ackRecv,
  input  logic byteMode,
  input  logic releaseEn,
  input  logic flagClr,
  input  logic frameStart,
  output logic lossFlag,
  output logic sdaOe,
  output logic lossEvent
);
  arbStrobes_t strb;

  i2c_arb_ctrl #(.SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .driveEn(driveEn), .ackRecv(ackRecv), .frameStart(frameStart),
    .strb(strb)
  );

  i2c_arb_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txBit(txBit),
    .driveEn(driveEn), .byteMode(byteMode), .releaseEn(releaseEn),
    .flagClr(flagClr), .lossFlag(lossFlag), .sdaOe(sdaOe),
    .lossEvent(lossEvent)
  );
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic driveEn,
  input logic byteMode,
  input logic releaseEn,
  input logic flagClr,
  input logic lossFlag,
  input logic sdaOe,
  input logic lossEvent
);
  // R8: event only alongside a freshly risen flag
  p_event_on_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    lossEvent |-> (lossFlag && !$past(lossFlag)));

  // R8: every flag rise produces the event
  p_rise_gives_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossFlag) |-> lossEvent);

  // R8: never two cycles long
  p_event_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    lossEvent |=> !lossEvent);

  // R5: frame-mode flag only leaves 1 through a clear
  p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lossFlag) && $past(byteMode) && !$past(flagClr)) |-> lossFlag);

  // R7: release takes effect with the flag rise
  p_release_same_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lossFlag) && $past(releaseEn)) |-> !sdaOe);

  // R7: released driver stays off until a clear
  p_release_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(sdaOe) && $past(driveEn) && driveEn && !$past(flagClr)) |-> !sdaOe);

  // R1: no drive without the local drive enable
  p_oe_needs_drive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> !sdaOe);
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk u_chk (.*);

// File: tb/i2c_arb_monitor_bench.sv
module i2c_arb_monitor_bench;
  logic clk = 1'b0;
  logic rstN;
  logic sclIn, sdaIn, txBit, driveEn, ackRecv, byteMode, releaseEn, flagClr, frameStart;
  logic lossFlag, sdaOe, lossEvent;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_arb_monitor u_i2c_arb_monitor (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .txBit(txBit),
    .driveEn(driveEn), .ackRecv(ackRecv), .byteMode(byteMode),
    .releaseEn(releaseEn), .flagClr(flagClr), .frameStart(frameStart),
    .lossFlag(lossFlag), .sdaOe(sdaOe), .lossEvent(lossEvent)
  );

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic sendBit(logic tx, logic sda);
    txBit = tx; sdaIn = sda;
    wclk(4); sclIn = 1'b1;
    wclk(4); sclIn = 1'b0;
    wclk(4);
  endtask

  task automatic beginFrame();
    sclIn = 1'b0; wclk(4);
    frameStart = 1'b1; wclk(1); frameStart = 1'b0; wclk(1);
  endtask

  task automatic clearAll();
    flagClr = 1'b1; wclk(1); flagClr = 1'b0; wclk(1);
  endtask

  task automatic testReset();
    chk("R1", "flag after reset", lossFlag, 1'b0);
    chk("R1", "event after reset", lossEvent, 1'b0);
    chk("R1", "oe after reset", sdaOe, 1'b1);
  endtask

  task automatic testLatency();
    byteMode = 1'b0; beginFrame();
    txBit = 1'b1; sdaIn = 1'b0; wclk(4);
    sclIn = 1'b1;
    wclk(2);
    chk("R2", "flag after 2 edges", lossFlag, 1'b0);
    wclk(1);
    chk("R2", "flag after 3 edges", lossFlag, 1'b1);
    chk("R8", "event on rise", lossEvent, 1'b1);
    wclk(1);
    chk("R8", "event one cycle", lossEvent, 1'b0);
    wclk(2); sclIn = 1'b0; wclk(4);
    clearAll();
    chk("R5", "clear works", lossFlag, 1'b0);
  endtask

  task automatic testLive();
    byteMode = 1'b0; beginFrame();
    sendBit(1'b1, 1'b1);
    chk("R3", "match keeps 0", lossFlag, 1'b0);
    sendBit(1'b1, 1'b0);
    chk("R3", "mismatch sets", lossFlag, 1'b1);
    sendBit(1'b0, 1'b0);
    chk("R3", "match clears", lossFlag, 1'b0);
    chk("R8", "no event on clear", lossEvent, 1'b0);
    sendBit(1'b1, 1'b0);
    chk("R3", "mismatch sets again", lossFlag, 1'b1);
    clearAll();
  endtask

  task automatic testSkip();
    byteMode = 1'b0; beginFrame();
    driveEn = 1'b0;
    sendBit(1'b1, 1'b0);
    chk("R6", "no compare without drive", lossFlag, 1'b0);
    driveEn = 1'b1;
    for (int i = 0; i < 7; i++) sendBit(1'b1, 1'b1);
    ackRecv = 1'b1;
    sendBit(1'b1, 1'b0);
    ackRecv = 1'b0;
    chk("R6", "ack bit skipped", lossFlag, 1'b0);
    for (int i = 0; i < 8; i++) sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b0);
    chk("R6", "9th bit compared without ackRecv", lossFlag, 1'b1);
    clearAll();
  endtask

  task automatic testByte();
    byteMode = 1'b1; beginFrame();
    sendBit(1'b0, 1'b0); sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b0);
    chk("R4", "no flag mid-frame", lossFlag, 1'b0);
    for (int i = 0; i < 5; i++) sendBit(1'b1, 1'b1);
    txBit = 1'b1; sdaIn = 1'b1; wclk(4); sclIn = 1'b1; wclk(4);
    chk("R4", "no flag at 9th rise", lossFlag, 1'b0);
    sclIn = 1'b0; wclk(2);
    chk("R4", "no flag before 9th fall seen", lossFlag, 1'b0);
    wclk(1);
    chk("R4", "flag at 9th fall", lossFlag, 1'b1);
    chk("R8", "event in frame mode", lossEvent, 1'b1);
    wclk(2);
    for (int i = 0; i < 9; i++) sendBit(1'b0, 1'b0);
    chk("R5", "held through matching frame", lossFlag, 1'b1);
    clearAll();
    chk("R5", "cleared by flagClr", lossFlag, 1'b0);
  endtask

  task automatic testFrameStart();
    byteMode = 1'b1; beginFrame();
    sendBit(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) sendBit(1'b1, 1'b1);
    beginFrame();
    sendBit(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) sendBit(1'b1, 1'b1);
    chk("R10", "old count does not end frame", lossFlag, 1'b0);
    for (int i = 0; i < 5; i++) sendBit(1'b1, 1'b1);
    chk("R10", "9th fall after restart ends frame", lossFlag, 1'b1);
    clearAll();
    beginFrame();
    sendBit(1'b1, 1'b0);
    beginFrame();
    for (int i = 0; i < 9; i++) sendBit(1'b1, 1'b1);
    chk("R10", "restart drops collected mismatch", lossFlag, 1'b0);
  endtask

  task automatic testRelease();
    byteMode = 1'b0; releaseEn = 1'b1; beginFrame();
    txBit = 1'b1; sdaIn = 1'b0; wclk(4); sclIn = 1'b1;
    wclk(2);
    chk("R7", "oe before set", sdaOe, 1'b1);
    wclk(1);
    chk("R7", "oe drops with flag", sdaOe, 1'b0);
    wclk(1); sclIn = 1'b0; wclk(4);
    sendBit(1'b1, 1'b1);
    chk("R3", "live match clears flag", lossFlag, 1'b0);
    chk("R7", "oe stays released", sdaOe, 1'b0);
    clearAll();
    chk("R7", "oe back after clear", sdaOe, 1'b1);
    releaseEn = 1'b0;
  endtask

  task automatic testClash();
    byteMode = 1'b0; beginFrame();
    txBit = 1'b1; sdaIn = 1'b0; wclk(4); sclIn = 1'b1;
    wclk(2);
    flagClr = 1'b1; wclk(1); flagClr = 1'b0;
    chk("R9", "set wins over clear", lossFlag, 1'b1);
    chk("R9", "event on contested set", lossEvent, 1'b1);
    wclk(1); sclIn = 1'b0; wclk(4);
    clearAll();
  endtask

  initial begin
    rstN = 1'b0; sclIn = 1'b1; sdaIn = 1'b1; txBit = 1'b1; driveEn = 1'b1;
    ackRecv = 1'b0; byteMode = 1'b0; releaseEn = 1'b0; flagClr = 1'b0;
    frameStart = 1'b0;
    wclk(3);
    chk("R1", "flag in reset", lossFlag, 1'b0);
    rstN = 1'b1;
    wclk(4);
    testReset();
    testLatency();
    testLive();
    testSkip();
    testByte();
    testFrameStart();
    testRelease();
    testClash();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule